// File: doc/BRIEF.md
# Per-Lane Link Error Monitor

This block sits behind the 8b/10b decoders of a multi-lane serial receive link. For every active lane it takes the decoded octet, its K flag, the decoder's disparity and not-in-table flags, and a strobe from the local multiframe counter. From these it builds a 32-bit status word. The word holds three sticky error flags per lane and a global alarm, and reading the word clears it. Each lane also has a saturating error counter, a per-lane count of the misaligned multiframe alignment characters seen in a row, and a one-cycle request that tells the SYNC logic about any error.

Software, or a small controller, reads the status word and the counters through a plain read port. The port takes a select and a read strobe, and returns data in the same cycle. One control input clears the counters by being turned off and then on again. Another control input stops errors from reaching the SYNC request. The number of lanes, the counter width and the run length that raises the alignment alarm are parameters.

Top module: `lane_err_mon`

## Requirements
- R1: After reset, the status word, every lane counter, `align_alarm_o` and `sync_err_req_o` are all zero.
- R2: Lane n owns status bits 3n+2..3n. Within that field, bit 2 is an unexpected K character, bit 1 is a disparity error and bit 0 is a not-in-table error. Bits of lanes at or above NUM_LANES read as zero, and bits 30 down to 3*NUM_LANES read as zero (this includes 28:24).
- R3: A status bit stays set until the status word is read, that is, until a clock edge with `rd_en_i` high and `rd_sel_i` equal to 0. That read returns the old word and clears every bit.
- R4: An error captured at the same edge as a status read is set in the word after the clear.
- R5: A K character counts as unexpected unless its octet is 0xBC, 0x1C, 0x9C, 0xFC or 0x7C. An octet with the K flag low is never an unexpected K.
- R6: The multiframe alignment character is 0x7C with the K flag set. It is misaligned when the lane's `lane_mf_edge_i` bit is low in that cycle. Seven misaligned alignment characters in a row on any one lane set status bit 31. An aligned alignment character restarts the run, and other characters do not affect it. `align_alarm_o` shows bit 31, which is cleared by a status read like the other bits.
- R7: While `cnt_en_i` is high, a lane counter adds one for the disparity flag and one for the not-in-table flag, so both together add two. While `cnt_en_i` is low, the counter holds its value.
- R8: At the first edge where `cnt_en_i` is high after it was low, every counter becomes zero, and errors at that edge are not counted.
- R9: A counter stops at its maximum value, 2^CNT_W-1.
- R10: `sync_err_req_o` is high for exactly the one cycle after an edge that captured any error flag (R2) on any lane. It stays low for errors captured while `sync_rpt_dis_i` is high.
- R11: The read select works as follows: 0 gives the status word, k in 1..NUM_LANES gives the counter of lane k-1 zero-extended to 32 bits, and any other value gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_octet_i | input | 8*NUM_LANES | Decoded octet per lane, lane n at bits 8n+7..8n |
| lane_is_k_i | input | NUM_LANES | Octet is a control (K) character |
| lane_disp_err_i | input | NUM_LANES | Decoder disparity error |
| lane_nit_err_i | input | NUM_LANES | Decoder not-in-table error |
| lane_mf_edge_i | input | NUM_LANES | Local multiframe boundary position for this octet |
| cnt_en_i | input | 1 | Error counter enable; turning it off and on again clears the counters |
| sync_rpt_dis_i | input | 1 | Suppress error reporting to the SYNC logic |
| rd_en_i | input | 1 | Read strobe; clears the status word when the select is 0 |
| rd_sel_i | input | $clog2(NUM_LANES+1) | Read select |
| rd_data_o | output | 32 | Read data for the current select |
| lane_cnt_o | output | CNT_W*NUM_LANES | Lane counters, lane n at bits CNT_W*n+CNT_W-1..CNT_W*n |
| align_alarm_o | output | 1 | Lane alignment alarm (status bit 31) |
| sync_err_req_o | output | 1 | One-cycle error request for the SYNC logic |

## Verification
The hardest situation to reach from the ports is the alignment alarm threshold. The run counter inside the block cannot be seen, so the bench makes it visible through bit 31. It sends six misaligned alignment characters and checks that no alarm is raised. It then sends one aligned character, which must restart the run, and six more misaligned characters, and again checks that there is no alarm. Only the seventh misaligned character in a row must set the bit. Counter saturation is hard to reach for the same reason, so the bench builds the block with a 4-bit counter and sends double errors past the limit. It also sends an error in the same cycle as a status read.

// File: rtl/lem_pkg.sv
`timescale 1ns/1ps
package lem_pkg;
   localparam int         OCT_W   = 8;
   localparam logic [7:0] K_ALIGN = 8'h7C;

   // Error flags of one lane in status-field order (MSB first)
   typedef struct packed {
      logic unexp_k;
      logic disp;
      logic nit;
   } lane_err_t;

   localparam int ERR_W = $bits(lane_err_t);

   function automatic logic k_is_legal(input logic [7:0] oct);
      return (oct == 8'hBC) || (oct == 8'h1C) || (oct == 8'h9C) ||
             (oct == 8'hFC) || (oct == K_ALIGN);
   endfunction
endpackage

// File: rtl/lem_lane.sv
`timescale 1ns/1ps
module lem_lane
   import lem_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter int ALIGN_RUN = 7
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [OCT_W-1:0] octet_i,
   input  logic             is_k_i,
   input  logic             disp_err_i,
   input  logic             nit_err_i,
   input  logic             mf_edge_i,
   input  logic             cnt_en_i,
   output lane_err_t        err_o,
   output logic             align_fail_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam int               RUN_W    = $clog2(ALIGN_RUN + 1);
   localparam int               SUM_W    = CNT_W + 1;
   localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(ALIGN_RUN);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(ALIGN_RUN - 1);

   logic             is_align, mis_align;
   logic [RUN_W-1:0] run_q;
   logic             en_q;
   logic [CNT_W-1:0] cnt_q;
   logic [1:0]       inc;
   logic [SUM_W-1:0] sum;

   assign is_align  = is_k_i && (octet_i == K_ALIGN);
   assign mis_align = is_align && !mf_edge_i;

   always_comb begin
      err_o.unexp_k = is_k_i && !k_is_legal(octet_i);
      err_o.disp    = disp_err_i;
      err_o.nit     = nit_err_i;
   end

   // count of misaligned alignment characters in a row
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           run_q <= '0;
      else if (is_align) begin
         if (mf_edge_i)      run_q <= '0;
         else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
      end
   end

   assign align_fail_o = mis_align && (run_q >= RUN_LAST);

   // saturating error counter, cleared when the enable turns on
   assign inc = {1'b0, disp_err_i} + {1'b0, nit_err_i};
   assign sum = {1'b0, cnt_q} + SUM_W'(inc);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q  <= 1'b0;
         cnt_q <= '0;
      end else begin
         en_q <= cnt_en_i;
         if (cnt_en_i && !en_q) cnt_q <= '0;
         else if (cnt_en_i)     cnt_q <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
      end
   end

   assign cnt_o = cnt_q;

   // R7
   cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cnt_en_i |=> $stable(cnt_q));
   // R9
   cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_en_i && en_q && (cnt_q == '1)) |=> (cnt_q == '1));
   // R6
   run_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q <= RUN_MAX);
endmodule

// File: rtl/lem_status.sv
`timescale 1ns/1ps
module lem_status
   import lem_pkg::*;
#(
   parameter int NUM_LANES = 8
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic [ERR_W*NUM_LANES-1:0] lane_err_i,
   input  logic [NUM_LANES-1:0]       align_fail_i,
   input  logic                       rd_clr_i,
   input  logic                       sync_rpt_dis_i,
   output logic [31:0]                stat_word_o,
   output logic                       alarm_o,
   output logic                       sync_req_o
);
   localparam int FLD_W = ERR_W * NUM_LANES;

   logic [FLD_W-1:0] lane_q;
   logic             alarm_q, sync_q, any_align, any_err;

   assign any_align = |align_fail_i;
   assign any_err   = |lane_err_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lane_q  <= '0;
         alarm_q <= 1'b0;
         sync_q  <= 1'b0;
      end else begin
         lane_q  <= (rd_clr_i ? '0 : lane_q) | lane_err_i;
         alarm_q <= (rd_clr_i ? 1'b0 : alarm_q) | any_align;
         sync_q  <= any_err && !sync_rpt_dis_i;
      end
   end

   always_comb begin
      stat_word_o            = '0;
      stat_word_o[FLD_W-1:0] = lane_q;
      stat_word_o[31]        = alarm_q;
   end

   assign alarm_o    = alarm_q;
   assign sync_req_o = sync_q;

   // R3
   sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_clr_i |=> ((lane_q & $past(lane_q)) == $past(lane_q)));
   // R4
   rd_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_clr_i |=> ((lane_q & $past(lane_err_i)) == $past(lane_err_i)));
   // R10
   sync_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sync_rpt_dis_i |=> !sync_q);
   // R6
   alarm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (alarm_q && !rd_clr_i) |=> alarm_q);
endmodule

// File: rtl/lane_err_mon.sv
`timescale 1ns/1ps
module lane_err_mon
   import lem_pkg::*;
#(
   parameter int NUM_LANES = 8,
   parameter int CNT_W     = 32,
   parameter int ALIGN_RUN = 7,
   localparam int SEL_W    = $clog2(NUM_LANES + 1)
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic [OCT_W*NUM_LANES-1:0] lane_octet_i,
   input  logic [NUM_LANES-1:0]       lane_is_k_i,
   input  logic [NUM_LANES-1:0]       lane_disp_err_i,
   input  logic [NUM_LANES-1:0]       lane_nit_err_i,
   input  logic [NUM_LANES-1:0]       lane_mf_edge_i,
   input  logic                       cnt_en_i,
   input  logic                       sync_rpt_dis_i,
   input  logic                       rd_en_i,
   input  logic [SEL_W-1:0]           rd_sel_i,
   output logic [31:0]                rd_data_o,
   output logic [CNT_W*NUM_LANES-1:0] lane_cnt_o,
   output logic                       align_alarm_o,
   output logic                       sync_err_req_o
);
   if (NUM_LANES < 1 || NUM_LANES > 8) begin : g_bad_lanes
      $error("lane_err_mon: NUM_LANES must be 1..8");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("lane_err_mon: CNT_W must be 2..32");
   end
   if (ALIGN_RUN < 2) begin : g_bad_run
      $error("lane_err_mon: ALIGN_RUN must be at least 2");
   end

   logic [ERR_W*NUM_LANES-1:0] err_bus;
   logic [NUM_LANES-1:0]       fail_bus;
   logic [CNT_W-1:0]           cnt_arr [NUM_LANES];
   logic [31:0]                stat_word;
   logic                       rd_clr;

   for (genvar n = 0; n < NUM_LANES; n++) begin : g_lane
      lane_err_t err_n;
      lem_lane #(.CNT_W(CNT_W), .ALIGN_RUN(ALIGN_RUN)) u_lane (
         .clk_i        (clk_i),
         .rst_ni       (rst_ni),
         .octet_i      (lane_octet_i[OCT_W*n +: OCT_W]),
         .is_k_i       (lane_is_k_i[n]),
         .disp_err_i   (lane_disp_err_i[n]),
         .nit_err_i    (lane_nit_err_i[n]),
         .mf_edge_i    (lane_mf_edge_i[n]),
         .cnt_en_i     (cnt_en_i),
         .err_o        (err_n),
         .align_fail_o (fail_bus[n]),
         .cnt_o        (cnt_arr[n])
      );
      assign err_bus[ERR_W*n +: ERR_W]    = err_n;
      assign lane_cnt_o[CNT_W*n +: CNT_W] = cnt_arr[n];
   end

   assign rd_clr = rd_en_i && (rd_sel_i == '0);

   lem_status #(.NUM_LANES(NUM_LANES)) u_status (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .lane_err_i     (err_bus),
      .align_fail_i   (fail_bus),
      .rd_clr_i       (rd_clr),
      .sync_rpt_dis_i (sync_rpt_dis_i),
      .stat_word_o    (stat_word),
      .alarm_o        (align_alarm_o),
      .sync_req_o     (sync_err_req_o)
   );

   always_comb begin
      rd_data_o = '0;
      if (rd_sel_i == '0) rd_data_o = stat_word;
      for (int i = 0; i < NUM_LANES; i++) begin
         if (rd_sel_i == SEL_W'(i + 1)) rd_data_o = 32'(cnt_arr[i]);
      end
   end

   // R6
   alarm_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !align_alarm_o || (rd_sel_i != '0) || rd_data_o[31]);
endmodule

// File: tb/lane_err_mon_tb.sv
`timescale 1ns/1ps
module lane_err_mon_tb;
   localparam int NL = 4;
   localparam int CW = 4;
   localparam int SW = $clog2(NL + 1);

   logic            clk = 1'b0;
   logic            rst_n;
   logic [8*NL-1:0] octet;
   logic [NL-1:0]   is_k, disp, nit, mf;
   logic            cnt_en, sync_dis, rd_en;
   logic [SW-1:0]   rd_sel;
   logic [31:0]     rd_data;
   logic [CW*NL-1:0] cnt_bus;
   logic            alarm, sync_req;

   always #10 clk = ~clk;

   lane_err_mon #(.NUM_LANES(NL), .CNT_W(CW), .ALIGN_RUN(7)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .lane_octet_i(octet), .lane_is_k_i(is_k),
      .lane_disp_err_i(disp), .lane_nit_err_i(nit), .lane_mf_edge_i(mf),
      .cnt_en_i(cnt_en), .sync_rpt_dis_i(sync_dis), .rd_en_i(rd_en),
      .rd_sel_i(rd_sel), .rd_data_o(rd_data), .lane_cnt_o(cnt_bus),
      .align_alarm_o(alarm), .sync_err_req_o(sync_req));

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } exp_t;
   exp_t sbq[$];
   int n_run = 0, n_fail = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compares read data mid-cycle against the scoreboard
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         #5;
         if (rd_en && sbq.size() > 0) begin
            e = sbq.pop_front();
            chk(e.tag, rd_data, e.exp);
         end
      end
   end

   task automatic idle();
      octet = '0; is_k = '0; disp = '0; nit = '0; mf = '0;
   endtask

   task automatic drive(input int ln, input logic [7:0] o, input logic k,
                        input logic d, input logic n, input logic m);
      @(negedge clk);
      idle();
      octet[ln*8 +: 8] = o; is_k[ln] = k; disp[ln] = d; nit[ln] = n; mf[ln] = m;
      @(negedge clk);
      idle();
   endtask

   task automatic rd(input logic [SW-1:0] sel, input logic [31:0] exp, input string tag);
      exp_t e;
      @(negedge clk);
      e.exp = exp; e.tag = tag;
      sbq.push_back(e);
      rd_sel = sel; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0; rd_sel = '0;
   endtask

   function automatic logic [31:0] cnt_of(input int ln);
      return 32'(cnt_bus[ln*CW +: CW]);
   endfunction

   initial begin
      #(200000 * 20);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      exp_t e;
      rst_n = 1'b0; idle(); cnt_en = 1'b0; sync_dis = 1'b0; rd_en = 1'b0; rd_sel = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 sync", 32'(sync_req), 0);
      chk("R1 alarm", 32'(alarm), 0);
      chk("R1 counters", 32'(cnt_bus), 0);
      rd(0, 32'h0, "R1 status");

      // R2 / R3: lane 1 disparity -> bit 4, then cleared
      drive(1, 8'h00, 0, 1, 0, 0);
      rd(0, 32'h0000_0010, "R2 lane1 disparity");
      rd(0, 32'h0, "R3 cleared by read");

      // R5: unexpected K vs legal K
      drive(2, 8'h00, 0, 0, 1, 0);
      drive(3, 8'h5C, 1, 0, 0, 0);
      drive(0, 8'hBC, 1, 0, 0, 0);
      drive(0, 8'h1C, 1, 0, 0, 0);
      drive(0, 8'h9C, 1, 0, 0, 0);
      drive(0, 8'hFC, 1, 0, 0, 0);
      drive(0, 8'h7C, 1, 0, 0, 1);
      drive(1, 8'h5C, 0, 0, 0, 0);
      rd(0, 32'h0000_0840, "R5 R2 lane3 unexp K, lane2 nit");

      // R4: error in the same cycle as the read
      @(negedge clk);
      e.exp = 32'h0; e.tag = "R4 read value";
      sbq.push_back(e);
      nit[0] = 1'b1; rd_en = 1'b1; rd_sel = '0;
      @(negedge clk);
      idle(); rd_en = 1'b0;
      rd(0, 32'h0000_0001, "R4 error survives clear");

      // R10: sync request pulse and suppression
      drive(2, 8'h00, 0, 0, 1, 0);
      #1 chk("R10 request high", 32'(sync_req), 1);
      @(posedge clk); #1 chk("R10 single cycle", 32'(sync_req), 0);
      sync_dis = 1'b1;
      drive(2, 8'h00, 0, 0, 1, 0);
      #1 chk("R10 suppressed", 32'(sync_req), 0);
      sync_dis = 1'b0;
      rd(0, 32'h0000_0040, "R10 status still recorded");

      // R7 / R8 / R11: counters
      @(negedge clk); cnt_en = 1'b1;
      @(negedge clk);
      chk("R8 cleared on enable", cnt_of(0), 0);
      drive(0, 8'h00, 0, 1, 1, 0);
      chk("R7 double error adds two", cnt_of(0), 2);
      drive(0, 8'h00, 0, 0, 1, 0);
      chk("R7 nit adds one", cnt_of(0), 3);
      rd(1, 32'd3, "R11 lane0 counter");
      rd(2, 32'd0, "R11 lane1 counter");
      rd(7, 32'd0, "R11 out of range select");
      @(negedge clk); cnt_en = 1'b0;
      drive(0, 8'h00, 0, 1, 1, 0);
      chk("R7 held while disabled", cnt_of(0), 3);
      @(negedge clk); cnt_en = 1'b1;
      @(negedge clk);
      chk("R8 re-enable clears", cnt_of(0), 0);
      repeat (10) drive(0, 8'h00, 0, 1, 1, 0);
      chk("R9 saturated", cnt_of(0), 15);
      drive(0, 8'h00, 0, 1, 0, 0);
      chk("R9 stays at max", cnt_of(0), 15);
      rd(1, 32'd15, "R11 R9 saturated via read");
      rd(0, 32'h0000_0003, "R3 lane0 flags sticky");

      // R6: alignment alarm threshold
      repeat (6) drive(2, 8'h7C, 1, 0, 0, 0);
      chk("R6 six misaligned no alarm", 32'(alarm), 0);
      drive(2, 8'h7C, 1, 0, 0, 1);
      repeat (6) drive(2, 8'h7C, 1, 0, 0, 0);
      chk("R6 run restarted", 32'(alarm), 0);
      drive(2, 8'h7C, 1, 0, 0, 0);
      chk("R6 seventh raises alarm", 32'(alarm), 1);
      rd(0, 32'h8000_0000, "R6 bit31 in status");
      chk("R6 alarm cleared by read", 32'(alarm), 0);

      // R2: every flag on every lane, upper lanes stay zero
      @(negedge clk);
      octet = {NL{8'h5C}}; is_k = '1; disp = '1; nit = '1;
      @(negedge clk);
      idle();
      rd(0, 32'h0000_0FFF, "R2 all lanes packed");

      wait (sbq.size() == 0);
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule